// File: doc/BRIEF.md
# Edge-Triggered Counter Capture with Input Filter

This block timestamps events on an asynchronous input pin. It watches the pin through a two-flop synchroniser, detects either a rising or a falling transition, and at that moment stores the value of an external free-running counter in a capture register. Each capture raises a sticky flag, and an interrupt request follows the flag while the interrupt enable is high. Software acknowledges an event with a one-cycle clear strobe.

For noisy pins an optional digital filter can be switched in. The filtered level follows the synchronised pin only once four consecutive synchronised samples agree. Pulses shorter than that never reach the edge detector. The price is a fixed extra latency of four clock cycles.

Top module: `icap_unit`

## Requirements
- R1: With `filt_en` high, the level seen by the edge detector changes only after four consecutive equal synchronised samples of the pin. A pin pulse lasting three clocks produces no capture, and a pulse lasting four clocks produces one.
- R2: A pin level set up before clock edge j is captured at edge j+2 when `filt_en` is low, and at edge j+6 when `filt_en` is high.
- R3: `edge_rise` set to 0 selects a falling (1 to 0) transition of the detected level. `edge_rise` set to 1 selects a rising (0 to 1) transition. A transition of the other direction causes no capture.
- R4: On a capture, `cap_val` takes the value that `tmr_cnt` has at the capturing clock edge. Without a capture, `cap_val` holds.
- R5: Each capture sets `cap_flag`, which then stays high until it is cleared.
- R6: `cap_irq` is high exactly when `cap_flag` and `cap_ie` are both high.
- R7: `flag_clr` high at a clock edge clears `cap_flag`. When a capture happens at the same edge, the flag is set instead.
- R8: A capture overwrites `cap_val` even when `cap_flag` is still set from an earlier capture.
- R9: While `rst_n` is low, `cap_val` is 0 and `cap_flag` and `cap_irq` are low. The synchroniser, the filter and the edge history all reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous event pin |
| tmr_cnt | input | 16 | Free-running counter value to timestamp with |
| filt_en | input | 1 | 1 = four-sample noise filter in the path |
| edge_rise | input | 1 | 1 = rising transition captures, 0 = falling transition captures |
| cap_ie | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle strobe that clears the flag |
| cap_val | output | 16 | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
The flag update is where two functions can land in the same cycle: a new capture and a clear strobe. The bench provokes this in a directed case. It asserts `flag_clr` on exactly the edge that its latency count predicts for a capture, then expects the flag to remain high and the captured value to be new. Random runs hit the same collision repeatedly, because clear strobes are sprinkled at random over random pin activity. Each cycle is judged against an independent run-length model of the pin history.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int CNT_W_DEF   = 16;
  localparam int SYNC_DEF    = 2;
  localparam int FILT_LEN_DEF = 4;

  // A selected transition: level moved, and it moved to the chosen polarity.
  function automatic logic edge_hit(input logic cur, input logic prev, input logic rise);
    return (cur != prev) && (cur == rise);
  endfunction

  // Flag next state: a capture beats a clear.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '0;
        else        ff <= {ff[STAGES-2:0], din};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '0;
        else        ff <= din;
      end
    end
  endgenerate

  assign dout = ff[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic filt_q
);
  localparam int HW = LEN - 1;

  logic [HW-1:0] hist;
  logic [LEN-1:0] window;
  logic          agree;

  assign window = {hist, din};
  assign agree  = (&window) | ~(|window);

  generate
    if (HW > 1) begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[HW-2:0], din};
      end
    end else begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= '0;
        else        hist <= din;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     filt_q <= 1'b0;
    else if (agree) filt_q <= din;
  end
endmodule

// File: rtl/icap_edge.sv
module icap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  input  logic rise,
  output logic hit
);
  import icap_pkg::*;

  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sig;
  end

  assign hit = edge_hit(sig, prev, rise);
endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
  parameter int CNT_W    = icap_pkg::CNT_W_DEF,
  parameter int SYNC     = icap_pkg::SYNC_DEF,
  parameter int FILT_LEN = icap_pkg::FILT_LEN_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_pin,
  input  logic [CNT_W-1:0] tmr_cnt,
  input  logic             filt_en,
  input  logic             edge_rise,
  input  logic             cap_ie,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             cap_irq
);
  import icap_pkg::*;

  logic sync_q;
  logic filt_q;
  logic sel_sig;
  logic cap_evt;

  icap_sync #(.STAGES(SYNC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cap_pin),
    .dout (sync_q)
  );

  icap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (sync_q),
    .filt_q(filt_q)
  );

  assign sel_sig = filt_en ? filt_q : sync_q;

  icap_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  (sel_sig),
    .rise (edge_rise),
    .hit  (cap_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_val <= '0;
    else if (cap_evt) cap_val <= tmr_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_flag <= 1'b0;
    else        cap_flag <= flag_next(cap_flag, cap_evt, flag_clr);
  end

  assign cap_irq = cap_flag & cap_ie;
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tmr_cnt,
  input logic             edge_rise,
  input logic             cap_ie,
  input logic             flag_clr,
  input logic             sync_q,
  input logic             filt_q,
  input logic             sel_sig,
  input logic             cap_evt,
  input logic [CNT_W-1:0] cap_val,
  input logic             cap_flag,
  input logic             cap_irq
);
  AST_FILT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(sync_q, 1) == filt_q && $past(sync_q, 2) == filt_q &&
                                   $past(sync_q, 3) == filt_q && $past(sync_q, 4) == filt_q)); // R1
  AST_EDGE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> (sel_sig == edge_rise)); // R3
  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_val == $past(tmr_cnt))); // R4
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_val)); // R4
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_evt && !flag_clr) |=> $stable(cap_flag)); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_ie |-> !cap_irq); // R6
  AST_CLR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_evt) |=> !cap_flag); // R7
  AST_RST_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (cap_val == '0 && !cap_flag && !cap_irq)); // R9
endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tmr_cnt  (tmr_cnt),
  .edge_rise(edge_rise),
  .cap_ie   (cap_ie),
  .flag_clr (flag_clr),
  .sync_q   (sync_q),
  .filt_q   (filt_q),
  .sel_sig  (sel_sig),
  .cap_evt  (cap_evt),
  .cap_val  (cap_val),
  .cap_flag (cap_flag),
  .cap_irq  (cap_irq)
);

// File: tb/tb_icap_unit.sv
module tb_icap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cap_pin = 1'b0;
  logic [15:0] tmr_cnt = '0;
  logic        filt_en = 1'b0;
  logic        edge_rise = 1'b0;
  logic        cap_ie = 1'b0;
  logic        flag_clr = 1'b0;
  logic [15:0] cap_val;
  logic        cap_flag;
  logic        cap_irq;

  always #10 clk = ~clk;

  icap_unit dut (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .tmr_cnt(tmr_cnt),
    .filt_en(filt_en), .edge_rise(edge_rise), .cap_ie(cap_ie), .flag_clr(flag_clr),
    .cap_val(cap_val), .cap_flag(cap_flag), .cap_irq(cap_irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Independent model: pin history by age, filtered level, last detected level.
  logic [5:1]  mh = '0;
  logic        m_filt = 1'b0;
  logic        m_prev = 1'b0;
  logic        m_flag = 1'b0;
  logic [15:0] m_cap = '0;
  logic [15:0] cnt_drv = 16'h1000;

  function automatic logic run_of_four(input logic [5:1] h);
    return (h[2] == h[3]) && (h[3] == h[4]) && (h[4] == h[5]);
  endfunction

  task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, advance model, run one clock, compare.
  task automatic step(input logic p, input logic clr, input logic fe, input logic es, input logic ie);
    logic lvl;
    logic evt;
    cap_pin = p; flag_clr = clr; filt_en = fe; edge_rise = es; cap_ie = ie; tmr_cnt = cnt_drv;
    lvl = fe ? m_filt : mh[2];
    evt = (lvl != m_prev) && (lvl == es);
    if (evt) m_cap = cnt_drv;
    if (evt) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
    if (run_of_four(mh)) m_filt = mh[2];
    m_prev = lvl;
    mh = {mh[4:1], p};
    @(posedge clk);
    @(negedge clk);
    cnt_drv = cnt_drv + 16'd1;
    chk16("R4 captured value", cap_val, m_cap);
    chk1("R5 flag", cap_flag, m_flag);
    chk1("R6 irq", cap_irq, m_flag & ie);
  endtask

  task automatic hold(input int n, input logic p, input logic fe, input logic es);
    for (int i = 0; i < n; i++) step(p, 1'b0, fe, es, 1'b1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int lat;
    logic [15:0] c0;
    void'($urandom(32'h5eed_1c4));
    #1 rst_n = 1'b0;
    cap_ie = 1'b1;
    repeat (4) @(negedge clk);
    chk16("R9 reset cap_val", cap_val, 16'h0);
    chk1("R9 reset flag", cap_flag, 1'b0);
    chk1("R9 reset irq", cap_irq, 1'b0);
    rst_n = 1'b1;

    // R2 unfiltered latency and R4 value
    hold(6, 1'b0, 1'b0, 1'b1);
    c0 = cnt_drv;
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    lat = 0;
    while (!cap_flag && lat < 20) begin step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1); lat++; end
    chk_int("R2 unfiltered latency", lat, 2);
    chk16("R4 unfiltered stamp", cap_val, c0 + 16'd2);

    // R2 filtered latency
    hold(8, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    hold(6, 1'b0, 1'b1, 1'b1);
    c0 = cnt_drv;
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    lat = 0;
    while (!cap_flag && lat < 20) begin step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1); lat++; end
    chk_int("R2 filtered latency", lat, 6);
    chk16("R4 filtered stamp", cap_val, c0 + 16'd6);

    // R1 three-clock glitch rejected, four-clock pulse accepted
    hold(10, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    hold(3, 1'b1, 1'b1, 1'b1);
    hold(12, 1'b0, 1'b1, 1'b1);
    chk1("R1 short pulse ignored", cap_flag, 1'b0);
    hold(4, 1'b1, 1'b1, 1'b1);
    hold(12, 1'b0, 1'b1, 1'b1);
    chk1("R1 four-sample pulse captured", cap_flag, 1'b1);

    // R3 falling select ignores rise, takes fall
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    hold(5, 1'b1, 1'b0, 1'b0);
    chk1("R3 rise ignored when falling selected", cap_flag, 1'b0);
    hold(4, 1'b0, 1'b0, 1'b0);
    chk1("R3 fall captured", cap_flag, 1'b1);

    // R7 clear and capture on the same edge: capture wins
    c0 = cnt_drv;
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    chk1("R7 capture beats clear", cap_flag, 1'b1);
    chk16("R7 value on collision", cap_val, c0 + 16'd2);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    chk1("R7 clear alone", cap_flag, 1'b0);

    // R8 overwrite while flag set
    hold(3, 1'b0, 1'b0, 1'b1);
    hold(4, 1'b1, 1'b0, 1'b1);
    chk1("R8 first capture flag", cap_flag, 1'b1);
    hold(3, 1'b0, 1'b0, 1'b1);
    c0 = cnt_drv;
    hold(4, 1'b1, 1'b0, 1'b1);
    chk16("R8 overwrite with flag set", cap_val, c0 + 16'd2);

    // Random traffic against the model
    begin
      logic p = 1'b1;
      logic fe = 1'b0;
      logic es = 1'b1;
      logic ie = 1'b1;
      int run = 0;
      for (int k = 0; k < 4000; k++) begin
        if (run == 0) begin p = ~p; run = 1 + int'($urandom_range(7)); end
        run--;
        if ($urandom_range(199) == 0) fe = ~fe;
        if ($urandom_range(99) == 0) es = ~es;
        if ($urandom_range(31) == 0) ie = ~ie;
        if ($urandom_range(15) == 0) cnt_drv = 16'($urandom);
        step(p, ($urandom_range(7) == 0), fe, es, ie);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule